// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. An external one-pulse-per-second strobe advances it. Seconds, minutes and hours form a 24-hour time chain. Each midnight wrap advances the calendar chain: day of week, date, month, year-of-century and century. Month lengths are applied, and February gets 29 days when the year-of-century is a multiple of four.

Software reaches the block through a small word-addressed register bus. The update sequence runs in five steps:

1. Raise a time and/or calendar update request.
2. Wait for the acknowledge flag, which is set on the next second strobe.
3. Write the new values.
4. Clear the acknowledge flag.
5. Drop the requests. Counting resumes from the values written.

Three sticky status flags are provided. One is set on every second strobe, one on every minute wrap and one on every day wrap. Writing ones to the status-clear register clears them.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After reset the time register reads 0x00000000, the calendar register reads 0x01210020 (century 20, year 00, month 01, weekday 1, date 01), and the status and control registers read 0.
- R2: The time register (offset 0x08) holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, all BCD. Seconds and minutes wrap from 0x59 to 0x00 and carry upward, and hours wrap from 0x23 to 0x00.
- R3: The calendar register (offset 0x0C) holds century in bits 6:0, year in bits 15:8, month in bits 20:16, weekday (1 to 7) in bits 23:21 and date in bits 29:24, all BCD. A day wrap advances weekday (7 goes to 1) and date. Month wraps from 0x12 to 0x01 and increments the year, and year 0x99 wraps to 0x00 and increments the century.
- R4: The last date is 0x30 for months 04, 06, 09 and 11, and 0x31 for the other months except February. February ends on 0x29 when the BCD year is a multiple of four (00 included), and on 0x28 otherwise.
- R5: Control register (offset 0x00) bit 0 freezes the time fields and bit 1 freezes the calendar fields while set. Each freezes only its own fields.
- R6: Status bit 0 (acknowledge) is set at the first second strobe after an update request is raised. It stays set until a 1 is written to bit 0 of the status-clear register (offset 0x1C).
- R7: A write to the time or calendar register is ignored unless the matching control bit is set and has been acknowledged by a second strobe.
- R8: Clearing the control request bits resumes counting from the values that were written.
- R9: Status bit 2 is set on every second strobe, including while counting is frozen. It is cleared by writing a 1 to bit 2 of offset 0x1C.
- R10: Status bit 3 is set when the minutes advance (seconds wrap 0x59 to 0x00). Status bit 4 is set when the hours wrap from 0x23 to 0x00.
- R11: The mode register (offset 0x04) reads 0, which means 24-hour mode. Hours run past 0x12 to 0x13, and time register bit 22 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |

## Verification
Register reads are combinational, so a register write or a second strobe sampled at one rising edge is visible on the read port straight after that edge. The bench drives stimulus at falling edges and reads one nanosecond after the next falling edge. The acknowledge flag needs a whole strobe after the request edge. The bench therefore always issues a strobe after raising a request and before writing new values, and it checks that writes made before that strobe leave the register unchanged. Rollover results, including the status flags, are read back one cycle after the single strobe that causes them.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   typedef struct packed {
      logic [5:0] hour;
      logic [6:0] min;
      logic [6:0] sec;
   } rtc_time_t;

   typedef struct packed {
      logic [6:0] cent;
      logic [7:0] year;
      logic [4:0] month;
      logic [2:0] wday;
      logic [5:0] date;
   } rtc_cal_t;

   // Two-digit BCD increment; 0x99 wraps to 0x00.
   function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) begin
         r[3:0] = 4'd0;
         r[7:4] = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
      end else begin
         r[3:0] = v[3:0] + 4'd1;
         r[7:4] = v[7:4];
      end
      return r;
   endfunction

   // A BCD year is a multiple of four when the units digit is 0, 4 or 8
   // with an even tens digit, or 2 or 6 with an odd tens digit.
   function automatic logic bcd_mult4(input logic [7:0] y);
      logic u048, u26;
      u048 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      u26  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      return y[4] ? u26 : u048;
   endfunction

   function automatic logic [5:0] last_date(input logic [4:0] month, input logic leap);
      logic [5:0] d;
      case (month)
         5'h02:                      d = leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
         default:                    d = 6'h31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/bcd_rtc_time_chain.sv
module bcd_rtc_time_chain
   import bcd_rtc_pkg::*;
#(
   parameter logic [5:0] HOUR_LAST = 6'h23
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      ld,
   input  rtc_time_t ld_val,
   output rtc_time_t cur,
   output logic      min_wrap,
   output logic      day_wrap
);

   logic [7:0] sec_inc, min_inc, hour_inc;
   logic       sec_last, min_last, hour_last;
   rtc_time_t  nxt;

   assign sec_inc   = bcd_inc8({1'b0, cur.sec});
   assign min_inc   = bcd_inc8({1'b0, cur.min});
   assign hour_inc  = bcd_inc8({2'b00, cur.hour});
   assign sec_last  = (cur.sec  == 7'h59);
   assign min_last  = (cur.min  == 7'h59);
   assign hour_last = (cur.hour == HOUR_LAST);

   assign min_wrap = step && sec_last;
   assign day_wrap = step && sec_last && min_last && hour_last;

   always_comb begin
      nxt = cur;
      if (!sec_last) begin
         nxt.sec = sec_inc[6:0];
      end else begin
         nxt.sec = '0;
         if (!min_last) begin
            nxt.min = min_inc[6:0];
         end else begin
            nxt.min  = '0;
            nxt.hour = hour_last ? 6'h00 : hour_inc[5:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cur <= '0;
      else if (ld)   cur <= ld_val;
      else if (step) cur <= nxt;
   end

   // R2
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !ld && sec_last |=> cur.sec == 7'h00);

   // R2
   hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      day_wrap && !ld |=> cur.hour == 6'h00 && cur.min == 7'h00);

endmodule

// File: rtl/bcd_rtc_date_chain.sv
module bcd_rtc_date_chain
   import bcd_rtc_pkg::*;
#(
   parameter bit         LEAP_EN  = 1'b1,
   parameter logic [6:0] CENT_RST = 7'h20
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     step,
   input  logic     ld,
   input  rtc_cal_t ld_val,
   output rtc_cal_t cur
);

   logic       leap;
   logic [5:0] end_date;
   logic [7:0] date_inc, month_inc, year_inc, cent_inc;
   rtc_cal_t   nxt, rst_val;

   generate
      if (LEAP_EN) begin : g_leap
         assign leap = bcd_mult4(cur.year);
      end else begin : g_noleap
         assign leap = 1'b0;
      end
   endgenerate

   assign end_date  = last_date(cur.month, leap);
   assign date_inc  = bcd_inc8({2'b00, cur.date});
   assign month_inc = bcd_inc8({3'b000, cur.month});
   assign year_inc  = bcd_inc8(cur.year);
   assign cent_inc  = bcd_inc8({1'b0, cur.cent});

   always_comb begin
      rst_val       = '0;
      rst_val.cent  = CENT_RST;
      rst_val.month = 5'h01;
      rst_val.wday  = 3'd1;
      rst_val.date  = 6'h01;
   end

   always_comb begin
      nxt      = cur;
      nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
      if (cur.date != end_date) begin
         nxt.date = date_inc[5:0];
      end else begin
         nxt.date = 6'h01;
         if (cur.month != 5'h12) begin
            nxt.month = month_inc[4:0];
         end else begin
            nxt.month = 5'h01;
            nxt.year  = year_inc;
            if (cur.year == 8'h99) nxt.cent = cent_inc[6:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cur <= rst_val;
      else if (ld)   cur <= ld_val;
      else if (step) cur <= nxt;
   end

   // R4
   month_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !ld && cur.date == end_date |=> cur.date == 6'h01);

   // R3
   wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !ld && cur.wday == 3'd7 |=> cur.wday == 3'd1);

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  rtc_time_t         time_cur,
   input  rtc_cal_t          cal_cur,
   input  logic              min_wrap,
   input  logic              day_wrap,
   output logic              time_step,
   output logic              cal_step,
   output logic              time_ld,
   output logic              cal_ld,
   output rtc_time_t         time_ld_val,
   output rtc_cal_t          cal_ld_val,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h04);
   localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(8'h0C);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h18);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h1C);
   localparam int NREQ = 2;

   logic [NREQ-1:0] req_q, grant_q;
   logic [4:0]      stat_q, stat_nxt;
   logic            ack_set;

   assign time_step = sec_tick && !req_q[0];
   assign cal_step  = day_wrap && !req_q[1];
   assign time_ld   = wr_en && (addr == A_TIME) && grant_q[0];
   assign cal_ld    = wr_en && (addr == A_CAL)  && grant_q[1];

   assign time_ld_val.sec  = wdata[6:0];
   assign time_ld_val.min  = wdata[14:8];
   assign time_ld_val.hour = wdata[21:16];
   assign cal_ld_val.cent  = wdata[6:0];
   assign cal_ld_val.year  = wdata[15:8];
   assign cal_ld_val.month = wdata[20:16];
   assign cal_ld_val.wday  = wdata[23:21];
   assign cal_ld_val.date  = wdata[29:24];

   always_ff @(posedge clk) begin
      if (!rst_n)                          req_q <= '0;
      else if (wr_en && (addr == A_CTRL))  req_q <= wdata[NREQ-1:0];
   end

   generate
      for (genvar g = 0; g < NREQ; g++) begin : g_grant
         always_ff @(posedge clk) begin
            if (!rst_n) grant_q[g] <= 1'b0;
            else        grant_q[g] <= req_q[g] && (grant_q[g] || sec_tick);
         end
      end
   endgenerate

   assign ack_set = sec_tick && |(req_q & ~grant_q);

   always_comb begin
      stat_nxt = stat_q;
      if (wr_en && (addr == A_CLR)) stat_nxt = stat_q & ~wdata[4:0];
      if (ack_set)  stat_nxt[0] = 1'b1;
      if (sec_tick) stat_nxt[2] = 1'b1;
      if (min_wrap) stat_nxt[3] = 1'b1;
      if (day_wrap) stat_nxt[4] = 1'b1;
      stat_nxt[1] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_nxt;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: rdata[NREQ-1:0] = req_q;
         A_MODE: rdata = '0;
         A_TIME: begin
            rdata[6:0]   = time_cur.sec;
            rdata[14:8]  = time_cur.min;
            rdata[21:16] = time_cur.hour;
         end
         A_CAL: begin
            rdata[6:0]   = cal_cur.cent;
            rdata[15:8]  = cal_cur.year;
            rdata[20:16] = cal_cur.month;
            rdata[23:21] = cal_cur.wday;
            rdata[29:24] = cal_cur.date;
         end
         A_STAT:  rdata[4:0] = stat_q;
         default: rdata = '0;
      endcase
   end

   // R5
   time_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[0] && !time_ld |=> $stable(time_cur));

   // R6
   ack_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[0]) |-> $past(sec_tick));

   // R7
   time_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (addr == A_TIME) && !grant_q[0] && !time_step |=> $stable(time_cur));

   // R9
   sec_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> stat_q[2]);

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
   import bcd_rtc_pkg::*;
#(
   parameter int         ADDR_W   = 6,
   parameter int         DATA_W   = 32,
   parameter bit         LEAP_EN  = 1'b1,
   parameter logic [6:0] CENT_RST = 7'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   generate
      if (DATA_W < 30) begin : g_bad_data_w
         $error("bcd_rtc_calendar: DATA_W must hold bits up to 29");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("bcd_rtc_calendar: ADDR_W must reach offset 0x1C");
      end
   endgenerate

   rtc_time_t time_cur, time_ld_val;
   rtc_cal_t  cal_cur, cal_ld_val;
   logic      time_step, cal_step, time_ld, cal_ld, min_wrap, day_wrap;

   bcd_rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .time_cur(time_cur), .cal_cur(cal_cur),
      .min_wrap(min_wrap), .day_wrap(day_wrap),
      .time_step(time_step), .cal_step(cal_step),
      .time_ld(time_ld), .cal_ld(cal_ld),
      .time_ld_val(time_ld_val), .cal_ld_val(cal_ld_val),
      .rdata(bus_rdata)
   );

   bcd_rtc_time_chain #(.HOUR_LAST(6'h23)) u_time (
      .clk(clk), .rst_n(rst_n), .step(time_step), .ld(time_ld),
      .ld_val(time_ld_val), .cur(time_cur),
      .min_wrap(min_wrap), .day_wrap(day_wrap)
   );

   bcd_rtc_date_chain #(.LEAP_EN(LEAP_EN), .CENT_RST(CENT_RST)) u_date (
      .clk(clk), .rst_n(rst_n), .step(cal_step), .ld(cal_ld),
      .ld_val(cal_ld_val), .cur(cal_cur)
   );

   // R5
   cal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_step && !cal_ld |=> $stable(cal_cur));

endmodule

// File: tb/bcd_rtc_calendar_bench.sv
module bcd_rtc_calendar_bench;

   localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_TIME = 6'h08,
                          A_CAL = 6'h0C, A_STAT = 6'h18, A_CLR = 6'h1C;
   localparam int NV = 12;
   // {time_in, cal_in, time_expected, cal_expected, status_expected}
   localparam logic [159:0] VEC [0:NV-1] = '{
      {32'h00123456, 32'h01210020, 32'h00123457, 32'h01210020, 32'h04},
      {32'h00123459, 32'h01210020, 32'h00123500, 32'h01210020, 32'h0C},
      {32'h00095959, 32'h01210020, 32'h00100000, 32'h01210020, 32'h0C},
      {32'h00125959, 32'h01210020, 32'h00130000, 32'h01210020, 32'h0C},
      {32'h00235959, 32'h31F22320, 32'h00000000, 32'h01212420, 32'h1C},
      {32'h00235959, 32'h28622420, 32'h00000000, 32'h29822420, 32'h1C},
      {32'h00235959, 32'h28622320, 32'h00000000, 32'h01832320, 32'h1C},
      {32'h00235959, 32'h29822420, 32'h00000000, 32'h01A32420, 32'h1C},
      {32'h00235959, 32'h30A42420, 32'h00000000, 32'h01C52420, 32'h1C},
      {32'h00235959, 32'h31412420, 32'h00000000, 32'h01622420, 32'h1C},
      {32'h00235959, 32'h31F29920, 32'h00000000, 32'h01210021, 32'h1C},
      {32'h00235959, 32'h28622020, 32'h00000000, 32'h29822020, 32'h1C}
   };

   logic        clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   int          checks = 0, failures = 0;

   always #4 clk = ~clk;

   bcd_rtc_calendar u_bcd_rtc_calendar (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1 check(req, bus_rdata, exp);
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic load(input logic [31:0] t, input logic [31:0] c);
      wr(A_CTRL, 32'h3);
      tick();
      wr(A_TIME, t);
      wr(A_CAL, c);
      wr(A_CLR, 32'h1F);
      wr(A_CTRL, 32'h0);
   endtask

   function automatic string vtag(input int i);
      if (i < 3)  return "R2 R10";
      if (i == 3) return "R11";
      if (i == 4 || i == 10) return "R3 R8";
      return "R4";
   endfunction

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      rd_chk("R1 time", A_TIME, 32'h00000000);
      rd_chk("R1 cal",  A_CAL,  32'h01210020);
      rd_chk("R1 stat", A_STAT, 32'h00000000);
      rd_chk("R1 ctrl", A_CTRL, 32'h00000000);
      // R11: 24-hour mode select reads back as 0
      wr(A_MODE, 32'h0);
      rd_chk("R11 mode", A_MODE, 32'h00000000);

      // R7: write with no request is ignored
      wr(A_TIME, 32'h00112233);
      rd_chk("R7 no request", A_TIME, 32'h00000000);
      // R7: write after request but before acknowledge is ignored
      wr(A_CTRL, 32'h1);
      wr(A_TIME, 32'h00112233);
      rd_chk("R7 before ack", A_TIME, 32'h00000000);
      rd_chk("R6 no ack yet", A_STAT, 32'h00000000);
      tick();
      // R5 time frozen, R6 ack set, R9 second event while frozen
      rd_chk("R5 frozen", A_TIME, 32'h00000000);
      rd_chk("R6 R9 ack", A_STAT, 32'h00000005);
      wr(A_TIME, 32'h00112233);
      rd_chk("R7 granted", A_TIME, 32'h00112233);
      wr(A_CAL, 32'h15622420);
      rd_chk("R7 cal not requested", A_CAL, 32'h01210020);
      wr(A_CLR, 32'h1);
      rd_chk("R6 ack clear", A_STAT, 32'h00000004);
      wr(A_CLR, 32'h4);
      rd_chk("R9 clear", A_STAT, 32'h00000000);
      wr(A_CTRL, 32'h0);
      tick();
      rd_chk("R8 resume", A_TIME, 32'h00112234);
      wr(A_CLR, 32'h1F);

      // R5: calendar-only freeze while time runs through midnight
      load(32'h00235959, 32'h01210020);
      wr(A_CTRL, 32'h2);
      tick();
      rd_chk("R5 time runs", A_TIME, 32'h00000000);
      rd_chk("R5 cal held",  A_CAL,  32'h01210020);
      rd_chk("R5 R10 stat",  A_STAT, 32'h0000001D);
      wr(A_CTRL, 32'h0);
      wr(A_CLR, 32'h1F);

      for (int i = 0; i < NV; i++) begin
         load(VEC[i][159:128], VEC[i][127:96]);
         tick();
         rd_chk({vtag(i), " time"}, A_TIME, VEC[i][95:64]);
         rd_chk({vtag(i), " cal"},  A_CAL,  VEC[i][63:32]);
         rd_chk({vtag(i), " stat"}, A_STAT, VEC[i][31:0]);
         wr(A_CLR, 32'h1F);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule